// File: doc/BRIEF.md
# Endpoint Transfer Completion Tracker

This block follows a single endpoint transfer from the moment it is armed until it ends, and keeps the status word that driver software reads back afterwards. A start pulse loads the total byte count and the direction, which is transmit or receive. Each completed packet then arrives as a one-cycle event. The event carries the number of bytes moved, a short-packet flag, an isochronous flag, two isochronous receive error flags and a stall flag.

Each clean packet reduces the remaining count. A transmit transfer ends only when the count reaches zero. A receive transfer also ends when the host sends a short packet, and the unreceived byte count stays visible. An overflow, an isochronous receive failure or a stall ends the transfer at once with the matching status bit set. Success is reported only when active, halted, transaction error and data buffer error are all clear at completion.

Top module: `xfer_track`

## Requirements
- R1: After reset, remaining count, active, halted, transaction error, data buffer error, done and success outputs are all 0.
- R2: A start pulse while idle loads the remaining count from the programmed total and the direction (0 = transmit, 1 = receive), sets active, and clears the three error bits and success, visible the cycle after the pulse.
- R3: A start pulse while active is ignored: remaining count and direction are unchanged.
- R4: Each error-free packet event while active lowers the remaining count by exactly the packet's byte count, visible the cycle after the event.
- R5: A transmit transfer completes only when the remaining count reaches zero; the short-packet flag has no effect on a transmit transfer.
- R6: A receive transfer completes when the remaining count reaches zero or on an error-free packet whose short flag is 1, and the remaining count then holds the bytes not received.
- R7: On completion, active clears, done is 1 for exactly one cycle, and success is 1 only if halted, transaction error and data buffer error are all 0; status and success hold until the next accepted start.
- R8: A packet whose byte count exceeds the remaining count is an overflow in either direction: data buffer error sets, the remaining count becomes 0 and the transfer ends without success; a count equal to the remaining count is not an overflow.
- R9: On a receive transfer, a packet with the isochronous flag set and either isochronous error flag set sets transaction error, freezes the remaining count and ends the transfer without success; on a transmit transfer those error flags are ignored.
- R10: A packet event with the stall flag set sets halted, freezes the remaining count and ends the transfer without success.
- R11: Packet events while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arm a new transfer (taken only when idle) |
| start_total_i | input | CNT_W | Programmed total byte count |
| start_dir_i | input | 1 | Direction: 0 transmit, 1 receive |
| pkt_valid_i | input | 1 | One-cycle packet completion event |
| pkt_bytes_i | input | PKT_W | Bytes moved by the packet |
| pkt_short_i | input | 1 | Packet was shorter than maximum size |
| pkt_iso_i | input | 1 | Packet belongs to an isochronous endpoint |
| pkt_iso_err_i | input | 1 | Isochronous packet error |
| pkt_fulfill_err_i | input | 1 | Isochronous fulfillment error |
| pkt_stall_i | input | 1 | Endpoint halted by this packet |
| remain_o | output | CNT_W | Remaining byte count |
| active_o | output | 1 | Transfer in progress |
| halted_o | output | 1 | Halted status bit |
| xact_err_o | output | 1 | Transaction error status bit |
| dbuf_err_o | output | 1 | Data buffer error status bit |
| done_o | output | 1 | One-cycle completion pulse |
| success_o | output | 1 | Last transfer ended cleanly |

## Verification
A transmit transfer is split into several packets, with a short flag placed in the middle. This separates the zero-count rule from the short-packet rule. Receive transfers end on a short packet and also on exact exhaustion, and the overflow boundary is tried with a byte count equal to the remaining count and one byte above it. Error flags are applied with each direction to show that the isochronous errors affect only receive, and start and packet events are sent while idle or active to show which ones are dropped.

// File: rtl/xfer_track_pkg.sv
package xfer_track_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;

    // Classification of one packet event against the current transfer.
    typedef struct packed {
        logic ovf;      // byte count larger than remaining
        logic iso_err;  // isochronous receive failure
        logic stall;    // endpoint halted
        logic err;      // any of the above
        logic finish;   // clean packet that ends the transfer
    } pkt_verdict_t;

endpackage

// File: rtl/xfer_pkt_judge.sv
module xfer_pkt_judge
    import xfer_track_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PKT_W = 11
) (
    input  logic [CNT_W-1:0] remain_i,
    input  xfer_dir_e        dir_i,
    input  logic [PKT_W-1:0] bytes_i,
    input  logic             short_i,
    input  logic             iso_i,
    input  logic             iso_err_i,
    input  logic             fulfill_err_i,
    input  logic             stall_i,
    output pkt_verdict_t     verdict_o,
    output logic [CNT_W-1:0] remain_next_o
);

    localparam int W = (CNT_W > PKT_W) ? CNT_W : PKT_W;

    logic [W-1:0] rem_w;
    logic [W-1:0] byt_w;
    logic [W-1:0] diff_w;

    always_comb begin
        rem_w = '0;
        byt_w = '0;
        rem_w[CNT_W-1:0] = remain_i;
        byt_w[PKT_W-1:0] = bytes_i;
        diff_w = rem_w - byt_w;
        remain_next_o = diff_w[CNT_W-1:0];

        verdict_o.ovf     = (byt_w > rem_w);
        verdict_o.iso_err = (dir_i == DIR_RX) && iso_i && (iso_err_i || fulfill_err_i);
        verdict_o.stall   = stall_i;
        verdict_o.err     = verdict_o.ovf || verdict_o.iso_err || verdict_o.stall;
        verdict_o.finish  = !verdict_o.err &&
                            ((diff_w == '0) || ((dir_i == DIR_RX) && short_i));
    end

endmodule

// File: rtl/xfer_track_core.sv
module xfer_track_core
    import xfer_track_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] start_total_i,
    input  xfer_dir_e        start_dir_i,
    input  logic             pkt_valid_i,
    input  pkt_verdict_t     verdict_i,
    input  logic [CNT_W-1:0] remain_next_i,
    output logic [CNT_W-1:0] remain_o,
    output xfer_dir_e        dir_o,
    output logic             active_o,
    output logic             halted_o,
    output logic             xact_err_o,
    output logic             dbuf_err_o,
    output logic             done_o,
    output logic             success_o
);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
        xfer_dir_e        dir;
        logic             active;
        logic             halted;
        logic             xact;
        logic             dbuf;
        logic             done;
        logic             success;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.active && pkt_valid_i) begin
            if (verdict_i.ovf) begin
                st_d.dbuf   = 1'b1;
                st_d.remain = '0;
            end
            if (verdict_i.iso_err) st_d.xact = 1'b1;
            if (verdict_i.stall)   st_d.halted = 1'b1;
            if (verdict_i.err) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.remain = remain_next_i;
                if (verdict_i.finish) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                end
            end
        end else if (!st_q.active && start_i) begin
            st_d.remain  = start_total_i;
            st_d.dir     = start_dir_i;
            st_d.active  = 1'b1;
            st_d.halted  = 1'b0;
            st_d.xact    = 1'b0;
            st_d.dbuf    = 1'b0;
            st_d.success = 1'b0;
        end
        if (st_d.done) begin
            st_d.success = !(st_d.active || st_d.halted || st_d.xact || st_d.dbuf);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{remain: '0, dir: DIR_TX, default: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign remain_o   = st_q.remain;
    assign dir_o      = st_q.dir;
    assign active_o   = st_q.active;
    assign halted_o   = st_q.halted;
    assign xact_err_o = st_q.xact;
    assign dbuf_err_o = st_q.dbuf;
    assign done_o     = st_q.done;
    assign success_o  = st_q.success;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.active); // R7
    AST_SUCCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.success |-> !(st_q.halted || st_q.xact || st_q.dbuf || st_q.active)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && start_i && !pkt_valid_i) |=> ($stable(st_q.remain) && $stable(st_q.dir))); // R3
    AST_REMAIN_NONRISING: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |=> (st_q.remain <= $past(st_q.remain))); // R4
    AST_TX_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.success && st_q.dir == DIR_TX) |-> (st_q.remain == '0)); // R5
    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dbuf) |-> (st_q.remain == '0)); // R8
    AST_TX_NO_XACT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dir == DIR_TX) |-> !st_q.xact); // R9
    AST_IDLE_PKT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !start_i) |=> ($stable(st_q.remain) && !st_q.active && !st_q.done)); // R11

endmodule

// File: rtl/xfer_track.sv
module xfer_track
    import xfer_track_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PKT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] start_total_i,
    input  logic             start_dir_i,
    input  logic             pkt_valid_i,
    input  logic [PKT_W-1:0] pkt_bytes_i,
    input  logic             pkt_short_i,
    input  logic             pkt_iso_i,
    input  logic             pkt_iso_err_i,
    input  logic             pkt_fulfill_err_i,
    input  logic             pkt_stall_i,
    output logic [CNT_W-1:0] remain_o,
    output logic             active_o,
    output logic             halted_o,
    output logic             xact_err_o,
    output logic             dbuf_err_o,
    output logic             done_o,
    output logic             success_o
);

    pkt_verdict_t     verdict;
    logic [CNT_W-1:0] remain_next;
    xfer_dir_e        cur_dir;
    xfer_dir_e        new_dir;

    assign new_dir = xfer_dir_e'(start_dir_i);

    xfer_pkt_judge #(
        .CNT_W (CNT_W),
        .PKT_W (PKT_W)
    ) u_judge (
        .remain_i      (remain_o),
        .dir_i         (cur_dir),
        .bytes_i       (pkt_bytes_i),
        .short_i       (pkt_short_i),
        .iso_i         (pkt_iso_i),
        .iso_err_i     (pkt_iso_err_i),
        .fulfill_err_i (pkt_fulfill_err_i),
        .stall_i       (pkt_stall_i),
        .verdict_o     (verdict),
        .remain_next_o (remain_next)
    );

    xfer_track_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_total_i (start_total_i),
        .start_dir_i   (new_dir),
        .pkt_valid_i   (pkt_valid_i),
        .verdict_i     (verdict),
        .remain_next_i (remain_next),
        .remain_o      (remain_o),
        .dir_o         (cur_dir),
        .active_o      (active_o),
        .halted_o      (halted_o),
        .xact_err_o    (xact_err_o),
        .dbuf_err_o    (dbuf_err_o),
        .done_o        (done_o),
        .success_o     (success_o)
    );

endmodule

// File: tb/xfer_track_test.sv
module xfer_track_test;

    localparam int CNT_W = 16;
    localparam int PKT_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] start_total_i = '0;
    logic             start_dir_i = 1'b0;
    logic             pkt_valid_i = 1'b0;
    logic [PKT_W-1:0] pkt_bytes_i = '0;
    logic             pkt_short_i = 1'b0;
    logic             pkt_iso_i = 1'b0;
    logic             pkt_iso_err_i = 1'b0;
    logic             pkt_fulfill_err_i = 1'b0;
    logic             pkt_stall_i = 1'b0;
    logic [CNT_W-1:0] remain_o;
    logic             active_o, halted_o, xact_err_o, dbuf_err_o, done_o, success_o;

    xfer_track #(.CNT_W(CNT_W), .PKT_W(PKT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_total_i(start_total_i),
        .start_dir_i(start_dir_i), .pkt_valid_i(pkt_valid_i), .pkt_bytes_i(pkt_bytes_i),
        .pkt_short_i(pkt_short_i), .pkt_iso_i(pkt_iso_i), .pkt_iso_err_i(pkt_iso_err_i),
        .pkt_fulfill_err_i(pkt_fulfill_err_i), .pkt_stall_i(pkt_stall_i),
        .remain_o(remain_o), .active_o(active_o), .halted_o(halted_o),
        .xact_err_o(xact_err_o), .dbuf_err_o(dbuf_err_o), .done_o(done_o),
        .success_o(success_o)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    cmp_en = 1'b0;
    bit    ended = 1'b0;
    string cur_req = "R1";

    // Behavioural reference model
    int m_remain = 0;
    bit m_dir = 0, m_active = 0, m_halt = 0, m_xact = 0, m_dbuf = 0, m_done = 0, m_succ = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_remain = 0; m_dir = 0; m_active = 0; m_halt = 0;
            m_xact = 0; m_dbuf = 0; m_done = 0; m_succ = 0;
        end else begin
            m_done = 0;
            if (m_active && pkt_valid_i) begin
                bit ovf, isoe, err;
                ovf  = int'(pkt_bytes_i) > m_remain;
                isoe = m_dir && pkt_iso_i && (pkt_iso_err_i || pkt_fulfill_err_i);
                err  = ovf || isoe || pkt_stall_i;
                if (ovf)         begin m_dbuf = 1; m_remain = 0; end
                if (isoe)        m_xact = 1;
                if (pkt_stall_i) m_halt = 1;
                if (err) begin
                    m_active = 0; m_done = 1; m_succ = 0;
                end else begin
                    m_remain = m_remain - int'(pkt_bytes_i);
                    if (m_remain == 0 || (m_dir && pkt_short_i)) begin
                        m_active = 0; m_done = 1; m_succ = 1;
                    end
                end
            end else if (!m_active && start_i) begin
                m_remain = int'(start_total_i); m_dir = start_dir_i; m_active = 1;
                m_halt = 0; m_xact = 0; m_dbuf = 0; m_succ = 0;
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !ended) begin
            chk(cur_req, "remain",  remain_o,   m_remain);
            chk(cur_req, "active",  active_o,   m_active);
            chk(cur_req, "halted",  halted_o,   m_halt);
            chk(cur_req, "xact",    xact_err_o, m_xact);
            chk(cur_req, "dbuf",    dbuf_err_o, m_dbuf);
            chk(cur_req, "done",    done_o,     m_done);
            chk(cur_req, "success", success_o,  m_succ);
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    task automatic start(int total, bit dir);
        @(negedge clk);
        start_i = 1'b1; start_total_i = CNT_W'(total); start_dir_i = dir;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pkt(int b, bit sh = 0, bit iso = 0, bit ie = 0, bit fe = 0, bit stl = 0);
        @(negedge clk);
        pkt_valid_i = 1'b1; pkt_bytes_i = PKT_W'(b); pkt_short_i = sh;
        pkt_iso_i = iso; pkt_iso_err_i = ie; pkt_fulfill_err_i = fe; pkt_stall_i = stl;
        @(negedge clk);
        pkt_valid_i = 1'b0; pkt_short_i = 0; pkt_iso_i = 0;
        pkt_iso_err_i = 0; pkt_fulfill_err_i = 0; pkt_stall_i = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "remain", remain_o, 0);
        chk("R1", "active", active_o, 0);
        chk("R1", "status", {halted_o, xact_err_o, dbuf_err_o, done_o, success_o}, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R11: packet while idle ignored
        cur_req = "R11";
        pkt(7);
        chk("R11", "remain after idle packet", remain_o, 0);
        chk("R11", "done after idle packet", done_o, 0);

        // R2 / R4 / R5: transmit 100 bytes, short flag mid-way ignored
        cur_req = "R2";
        start(100, 0);
        chk("R2", "remain loaded", remain_o, 100);
        chk("R2", "active set", active_o, 1);
        cur_req = "R4";
        pkt(40);
        chk("R4", "remain after 40", remain_o, 60);
        cur_req = "R5";
        pkt(40, 1);
        chk("R5", "tx short ignored active", active_o, 1);
        chk("R5", "tx remain after short", remain_o, 20);
        // R3: start while active ignored
        cur_req = "R3";
        start(999, 1);
        chk("R3", "remain unchanged", remain_o, 20);
        cur_req = "R5";
        pkt(20);
        chk("R5", "tx done at zero", done_o, 1);
        chk("R7", "tx success", success_o, 1);
        chk("R7", "active cleared", active_o, 0);
        @(negedge clk);
        chk("R7", "done one cycle", done_o, 0);
        chk("R7", "success held", success_o, 1);

        // R6: receive ends on short packet, remainder kept
        cur_req = "R6";
        start(200, 1);
        pkt(64);
        pkt(10, 1);
        chk("R6", "rx short done", done_o, 1);
        chk("R6", "rx remain kept", remain_o, 126);
        chk("R6", "rx success", success_o, 1);
        // R6: receive exhausted exactly, R8 boundary (equal is not overflow)
        start(64, 1);
        pkt(64);
        chk("R8", "equal count no dbuf", dbuf_err_o, 0);
        chk("R6", "rx exact done success", success_o, 1);

        // R8: overflow on receive and transmit
        cur_req = "R8";
        start(50, 1);
        pkt(51);
        chk("R8", "rx ovf dbuf", dbuf_err_o, 1);
        chk("R8", "rx ovf remain zero", remain_o, 0);
        chk("R8", "rx ovf no success", success_o, 0);
        start(30, 0);
        chk("R2", "dbuf cleared by start", dbuf_err_o, 0);
        pkt(10);
        pkt(25);
        chk("R8", "tx ovf dbuf", dbuf_err_o, 1);
        chk("R8", "tx ovf done", done_o, 1);

        // R9: isochronous errors on receive, ignored on transmit
        cur_req = "R9";
        start(300, 1);
        pkt(100);
        pkt(50, 0, 1, 1, 0);
        chk("R9", "rx iso err xact", xact_err_o, 1);
        chk("R9", "rx iso remain frozen", remain_o, 200);
        chk("R9", "rx iso no success", success_o, 0);
        start(300, 1);
        pkt(20, 0, 1, 0, 1);
        chk("R9", "rx fulfill xact", xact_err_o, 1);
        chk("R9", "rx fulfill remain", remain_o, 300);
        start(80, 0);
        pkt(30, 0, 1, 1, 1);
        chk("R9", "tx iso flags ignored", xact_err_o, 0);
        chk("R9", "tx continues", active_o, 1);
        chk("R9", "tx remain", remain_o, 50);
        pkt(50);
        chk("R9", "tx completes clean", success_o, 1);
        // non-iso receive packet with error flags: no effect
        start(40, 1);
        pkt(40, 0, 0, 1, 1);
        chk("R9", "non-iso flags ignored", xact_err_o, 0);

        // R10: stall
        cur_req = "R10";
        start(500, 0);
        pkt(100);
        pkt(100, 0, 0, 0, 0, 1);
        chk("R10", "halted set", halted_o, 1);
        chk("R10", "remain frozen", remain_o, 400);
        chk("R10", "no success", success_o, 0);
        // combined errors
        start(10, 1);
        pkt(20, 0, 1, 1, 0, 1);
        chk("R10", "combined halted", halted_o, 1);
        chk("R9", "combined xact", xact_err_o, 1);
        chk("R8", "combined dbuf", dbuf_err_o, 1);

        cur_req = "R11";
        pkt(5);
        idle(3);
        chk("R11", "status held after idle pkt", halted_o, 1);
        finish_run();
    end

endmodule